// File: doc/BRIEF.md
# LCD Frame Fetch Sequencer

This block runs the per-frame control sequence ahead of an LCD framebuffer fetch. When software enables it, it first confirms that every buffer address in use lies inside an allowed address window. On each frame tick it can then read a palette header word from the start of the current buffer over a simple request/acknowledge memory port. The depth field of that word sets the pixel depth and the size of the header that comes before the pixel data.

For each frame it checks that the header plus the pixel data fit in the current buffer, with two bytes of slack. When the frame is accepted it puts out the fetch base address, the bytes per line, the pixel depth, the 12/16-bit pixel interpretation, and the first line and line count after the subpanel window is applied. It pulses a frame-accepted strobe that carries the index of the buffer used. In dual-buffer mode it then switches to the other buffer.

A depth code of zero skips the frame. A frame that does not fit raises a sync-error strobe and turns the sequencer off. A bad buffer address at enable time raises an address-error strobe and leaves the sequencer off. The memory itself and the pixel conversion are outside this block.

Top module: `lcd_fetch_seq`

## Requirements
- R1: On a frame tick while enabled and idle-waiting, if `pal_mode_i` is not 2 the block issues one header read with `mem_req_o` high and `mem_addr_o` equal to the current buffer's top address. It holds the request until `mem_ack_i` and latches `mem_rdata_i`. With `pal_mode_i` equal to 2 it issues no read and reuses the word latched last (zero after reset).
- R2: The depth code is bits 14:12 of the latched word. Code 1 gives 2 bpp, 2 gives 4 bpp, 3 gives 8 bpp, and 4 to 7 give 16 bpp, reported on `bpp_o`. Code 0 pulses `skip_o` for one cycle, produces no frame strobe, and the block stays enabled.
- R3: The data offset is 0x200 when a header was read and the code is 3 or more. It is 0x20 when a header was read and the code is 1 or 2, and 0 when no header was read. `fetch_base_o` equals the current top plus this offset.
- R4: A frame is accepted when offset + width×height×bpp/8 ≤ (end − top) + 2 for the current buffer. Otherwise the block pulses `sync_err_o` and becomes disabled.
- R5: An accepted frame pulses `frame_ok_o` for one cycle, with `frame_buf_o` holding the buffer index used and `line_bytes_o` equal to width×bpp/8. At most one of `frame_ok_o`, `skip_o`, `sync_err_o` and `addr_err_o` is high in any cycle.
- R6: When `dual_i` is high, the buffer index toggles between 0 (pair `buf0_*`) and 1 (pair `buf1_*`) after each accepted frame. When `dual_i` is low it stays put.
- R7: On `start_i` while disabled, the buf0 top and end addresses, plus the buf1 pair when `dual_i` is high, must each lie within [`addr_lo_i`, `addr_hi_i`]. If one does not, `addr_err_o` pulses and the block stays disabled.
- R8: If subpanel bit 31 is set and bit 29 is set, `first_line_o` is bits 25:16 and `line_cnt_o` is the height. If bit 31 is set and bit 29 is clear, `first_line_o` is 0 and `line_cnt_o` is bits 25:16. If bit 31 is clear, the first line is 0 and the count is the height.
- R9: `pix16_o` is high for an accepted frame only when the depth is 16 bpp and `tft_i` is high, which selects 16-bit over 12-bit pixels.
- R10: `cur_buf_o` reads 2'b11 while disabled. A successful start always resumes at buffer 0 (`cur_buf_o` = 2'b00).
- R11: `stop_i` disables the block on the next edge and outranks `start_i` and a frame completing in the same cycle, so that frame produces no strobe. Frame ticks are ignored while disabled or while a frame is in progress.
- R12: After reset the block is disabled (`cur_buf_o` = 2'b11), with `mem_req_o` and all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Enable request pulse |
| stop_i | input | 1 | Disable request pulse |
| tick_i | input | 1 | Frame tick |
| dual_i | input | 1 | Two-buffer ping-pong mode |
| pal_mode_i | input | 2 | Palette-load mode; 2 means no header |
| tft_i | input | 1 | 16-bit (high) or 12-bit (low) pixels at 16 bpp |
| width_i | input | LW | Pixels per line (1 to 1024) |
| height_i | input | LW | Lines per frame (1 to 1024) |
| subpanel_i | input | 32 | Subpanel window word |
| buf0_top_i | input | AW | Buffer 0 start address |
| buf0_end_i | input | AW | Buffer 0 end address |
| buf1_top_i | input | AW | Buffer 1 start address |
| buf1_end_i | input | AW | Buffer 1 end address |
| addr_lo_i | input | AW | Lowest valid address |
| addr_hi_i | input | AW | Highest valid address |
| mem_req_o | output | 1 | Header read request |
| mem_addr_o | output | AW | Header read address |
| mem_ack_i | input | 1 | Header read acknowledge |
| mem_rdata_i | input | 16 | Palette word 0 |
| cur_buf_o | output | 2 | Buffer index, 2'b11 when disabled |
| frame_ok_o | output | 1 | Frame accepted strobe |
| frame_buf_o | output | 1 | Buffer index of the accepted frame |
| fetch_base_o | output | AW | Pixel data start address |
| line_bytes_o | output | LW+1 | Bytes per line |
| bpp_o | output | 5 | Bits per pixel |
| pix16_o | output | 1 | 16-bit pixel interpretation |
| first_line_o | output | LW | First displayed line |
| line_cnt_o | output | LW | Number of lines |
| skip_o | output | 1 | Unsupported depth strobe |
| sync_err_o | output | 1 | Buffer overrun strobe |
| addr_err_o | output | 1 | Bad address at start strobe |

## Verification
Two things can land on the same clock edge: a stop request and a frame completing, and also a stop and a start. The bench selects the mode that needs no header, pulses a tick, and drives stop exactly in the one cycle in which the frame result is decided. It then checks that no frame strobe ever appears and that the buffer index reads as disabled. A second directed case raises start and stop together and checks that the block stays disabled.

// File: rtl/lcd_fetch_seq.sv
module lcd_fetch_seq #(
  parameter int AW = 32,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          tick_i,
  input  logic          dual_i,
  input  logic [1:0]    pal_mode_i,
  input  logic          tft_i,
  input  logic [LW-1:0] width_i,
  input  logic [LW-1:0] height_i,
  input  logic [31:0]   subpanel_i,
  input  logic [AW-1:0] buf0_top_i,
  input  logic [AW-1:0] buf0_end_i,
  input  logic [AW-1:0] buf1_top_i,
  input  logic [AW-1:0] buf1_end_i,
  input  logic [AW-1:0] addr_lo_i,
  input  logic [AW-1:0] addr_hi_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [15:0]   mem_rdata_i,
  output logic [1:0]    cur_buf_o,
  output logic          frame_ok_o,
  output logic          frame_buf_o,
  output logic [AW-1:0] fetch_base_o,
  output logic [LW:0]   line_bytes_o,
  output logic [4:0]    bpp_o,
  output logic          pix16_o,
  output logic [LW-1:0] first_line_o,
  output logic [LW-1:0] line_cnt_o,
  output logic          skip_o,
  output logic          sync_err_o,
  output logic          addr_err_o
);
  localparam int NW = AW + 2;
  localparam int HDR_BIG = 'h200;
  localparam int HDR_SMALL = 'h20;
  localparam int SLACK = 2;
  localparam logic [1:0] NO_HDR_MODE = 2'd2;

  typedef enum logic [1:0] {ST_OFF, ST_WAIT, ST_HDR, ST_CALC} st_t;

  st_t           state;
  logic          idx;
  logic          hdr_used;
  logic [2:0]    code;
  logic [AW-1:0] cur_top, cur_end;
  logic [4:0]    bpp_c;
  logic [NW-1:0] off_c, need_c;
  logic          fits_c, start_ok;
  logic          unused_bits;

  function automatic logic in_win(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                  input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  assign cur_top    = idx ? buf1_top_i : buf0_top_i;
  assign cur_end    = idx ? buf1_end_i : buf0_end_i;
  assign mem_req_o  = (state == ST_HDR);
  assign mem_addr_o = cur_top;
  assign cur_buf_o  = (state == ST_OFF) ? 2'b11 : {1'b0, idx};

  always_comb begin
    case (code)
      3'd1:    bpp_c = 5'd2;
      3'd2:    bpp_c = 5'd4;
      3'd3:    bpp_c = 5'd8;
      default: bpp_c = 5'd16;
    endcase
  end

  assign off_c  = !hdr_used ? '0 : (code >= 3'd3) ? NW'(HDR_BIG) : NW'(HDR_SMALL);
  assign need_c = off_c + ((NW'(width_i) * NW'(height_i) * NW'(bpp_c)) >> 3);
  assign fits_c = (NW'(cur_top) + need_c) <= (NW'(cur_end) + NW'(SLACK));

  assign start_ok = in_win(buf0_top_i, addr_lo_i, addr_hi_i) &&
                    in_win(buf0_end_i, addr_lo_i, addr_hi_i) &&
                    (!dual_i || (in_win(buf1_top_i, addr_lo_i, addr_hi_i) &&
                                 in_win(buf1_end_i, addr_lo_i, addr_hi_i)));

  assign unused_bits = ^{mem_rdata_i[15], mem_rdata_i[11:0], subpanel_i[30],
                         subpanel_i[28:26], subpanel_i[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_OFF;
      idx          <= 1'b0;
      hdr_used     <= 1'b0;
      code         <= 3'd0;
      frame_ok_o   <= 1'b0;
      frame_buf_o  <= 1'b0;
      fetch_base_o <= '0;
      line_bytes_o <= '0;
      bpp_o        <= '0;
      pix16_o      <= 1'b0;
      first_line_o <= '0;
      line_cnt_o   <= '0;
      skip_o       <= 1'b0;
      sync_err_o   <= 1'b0;
      addr_err_o   <= 1'b0;
    end else begin
      frame_ok_o <= 1'b0;
      skip_o     <= 1'b0;
      sync_err_o <= 1'b0;
      addr_err_o <= 1'b0;
      if (stop_i) begin
        state <= ST_OFF;
        idx   <= 1'b0;
      end else begin
        case (state)
          ST_OFF: if (start_i) begin
            if (start_ok) begin
              state <= ST_WAIT;
              idx   <= 1'b0;
            end else begin
              addr_err_o <= 1'b1;
            end
          end
          ST_WAIT: if (tick_i) begin
            hdr_used <= (pal_mode_i != NO_HDR_MODE);
            state    <= (pal_mode_i != NO_HDR_MODE) ? ST_HDR : ST_CALC;
          end
          ST_HDR: if (mem_ack_i) begin
            code  <= mem_rdata_i[14:12];
            state <= ST_CALC;
          end
          default: begin
            if (code == 3'd0) begin
              skip_o <= 1'b1;
              state  <= ST_WAIT;
            end else if (!fits_c) begin
              sync_err_o <= 1'b1;
              state      <= ST_OFF;
              idx        <= 1'b0;
            end else begin
              frame_ok_o   <= 1'b1;
              frame_buf_o  <= idx;
              fetch_base_o <= cur_top + AW'(off_c);
              line_bytes_o <= (LW+1)'((NW'(width_i) * NW'(bpp_c)) >> 3);
              bpp_o        <= bpp_c;
              pix16_o      <= tft_i && (bpp_c == 5'd16);
              if (subpanel_i[31] && subpanel_i[29]) begin
                first_line_o <= LW'(subpanel_i[25:16]);
                line_cnt_o   <= height_i;
              end else if (subpanel_i[31]) begin
                first_line_o <= '0;
                line_cnt_o   <= LW'(subpanel_i[25:16]);
              end else begin
                first_line_o <= '0;
                line_cnt_o   <= height_i;
              end
              if (dual_i) idx <= ~idx;
              state <= ST_WAIT;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_fetch_seq_chk.sv
module lcd_fetch_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_i,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    cur_buf_o,
  input logic          frame_ok_o,
  input logic          skip_o,
  input logic          sync_err_o,
  input logic          addr_err_o,
  input logic [4:0]    bpp_o,
  input logic          pix16_o
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i && !stop_i |=> mem_req_o && $stable(mem_addr_o)); // R1

  AST_BPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_o |-> (bpp_o == 5'd2 || bpp_o == 5'd4 || bpp_o == 5'd8 || bpp_o == 5'd16)); // R2

  AST_SYNC_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |-> cur_buf_o == 2'b11); // R4

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_ok_o, skip_o, sync_err_o, addr_err_o})); // R5

  AST_ADDR_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_o |-> cur_buf_o == 2'b11); // R7

  AST_PIX16_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_o && pix16_o |-> bpp_o == 5'd16); // R9

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cur_buf_o == 2'b11 |-> !mem_req_o); // R10

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> cur_buf_o == 2'b11 && !frame_ok_o && !skip_o && !sync_err_o); // R11
endmodule

bind lcd_fetch_seq lcd_fetch_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .mem_req_o(mem_req_o),
  .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o), .cur_buf_o(cur_buf_o),
  .frame_ok_o(frame_ok_o), .skip_o(skip_o), .sync_err_o(sync_err_o),
  .addr_err_o(addr_err_o), .bpp_o(bpp_o), .pix16_o(pix16_o)
);

// File: tb/lcd_fetch_seq_tb.sv
`timescale 1ns/1ps
module lcd_fetch_seq_tb;
  localparam int AW = 32;
  localparam int LW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, tick = 0, dual = 0, tft = 0;
  logic [1:0] pm = 0;
  logic [LW-1:0] w = 11'd8, h = 11'd8;
  logic [31:0] sp = 0;
  logic [AW-1:0] b0t = 32'h1000, b0e = 32'h9000, b1t = 32'h20000, b1e = 32'h28000;
  logic [AW-1:0] lo = 32'h800, hi = 32'h10000;
  logic mem_req, mem_ack = 0;
  logic [AW-1:0] mem_addr;
  logic [15:0] rdata = 0, pal_word = 0;
  logic [1:0] cur_buf;
  logic frame_ok, frame_buf, pix16, skip, sync_err, addr_err;
  logic [AW-1:0] fetch_base;
  logic [LW:0] line_bytes;
  logic [4:0] bpp;
  logic [LW-1:0] first_line, line_cnt;

  int total = 0, bad = 0, req_cnt = 0;
  logic [AW-1:0] last_addr = 0;

  always #2.5 clk = ~clk;

  lcd_fetch_seq #(.AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .tick_i(tick),
    .dual_i(dual), .pal_mode_i(pm), .tft_i(tft), .width_i(w), .height_i(h),
    .subpanel_i(sp), .buf0_top_i(b0t), .buf0_end_i(b0e), .buf1_top_i(b1t),
    .buf1_end_i(b1e), .addr_lo_i(lo), .addr_hi_i(hi), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(rdata),
    .cur_buf_o(cur_buf), .frame_ok_o(frame_ok), .frame_buf_o(frame_buf),
    .fetch_base_o(fetch_base), .line_bytes_o(line_bytes), .bpp_o(bpp),
    .pix16_o(pix16), .first_line_o(first_line), .line_cnt_o(line_cnt),
    .skip_o(skip), .sync_err_o(sync_err), .addr_err_o(addr_err)
  );

  always @(negedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      if (mem_req && !mem_ack) begin
        req_cnt <= req_cnt + 1;
        last_addr <= mem_addr;
      end
      mem_ack <= mem_req && !mem_ack;
      rdata <= pal_word;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
  endtask

  // kind: 0 accepted, 1 skipped, 2 sync error, -1 nothing
  task automatic run_frame(output int kind);
    kind = -1;
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    for (int i = 0; i < 12 && kind < 0; i++) begin
      if (frame_ok) kind = 0;
      else if (skip) kind = 1;
      else if (sync_err) kind = 2;
      if (kind < 0) @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [1:0]  pm;
    logic [2:0]  code;
    logic        tft;
    logic [10:0] w;
    logic [10:0] h;
    logic [31:0] sp;
    logic [1:0]  kind;
    logic [11:0] lb;
    logic [11:0] off;
    logic [10:0] first;
    logic [10:0] cnt;
    logic [4:0]  bpp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 3'd1, 1'b0, 11'd64,  11'd32,  32'h0,        2'd0, 12'd16,  12'h20,  11'd0, 11'd32,  5'd2},
    '{2'd0, 3'd2, 1'b1, 11'd100, 11'd50,  32'h0,        2'd0, 12'd50,  12'h20,  11'd0, 11'd50,  5'd4},
    '{2'd0, 3'd3, 1'b0, 11'd128, 11'd64,  32'h0,        2'd0, 12'd128, 12'h200, 11'd0, 11'd64,  5'd8},
    '{2'd0, 3'd5, 1'b0, 11'd128, 11'd120, 32'h800A0000, 2'd0, 12'd256, 12'h200, 11'd0, 11'd10,  5'd16},
    '{2'd0, 3'd7, 1'b1, 11'd160, 11'd100, 32'hA0050000, 2'd0, 12'd320, 12'h200, 11'd5, 11'd100, 5'd16},
    '{2'd1, 3'd4, 1'b1, 11'd16,  11'd16,  32'h20030000, 2'd0, 12'd32,  12'h200, 11'd0, 11'd16,  5'd16},
    '{2'd2, 3'd1, 1'b0, 11'd64,  11'd8,   32'h0,        2'd0, 12'd128, 12'h0,   11'd0, 11'd8,   5'd16},
    '{2'd0, 3'd0, 1'b0, 11'd8,   11'd8,   32'h0,        2'd1, 12'd0,   12'h0,   11'd0, 11'd0,   5'd0}
  };

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int kind, r0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(cur_buf == 2'b11, "R12 cur_buf after reset", cur_buf, 2'b11);
    chk(!mem_req && !frame_ok && !skip && !sync_err && !addr_err, "R12 outputs low",
        {mem_req, frame_ok, skip, sync_err, addr_err}, 0);
    rst_n = 1;
    @(negedge clk);

    // R11 tick while disabled is ignored
    r0 = req_cnt;
    run_frame(kind);
    chk(kind == -1 && req_cnt == r0, "R11 tick ignored while off", kind, -1);

    // R7 bad buf1 address with dual -> error
    dual = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(addr_err == 1'b1, "R7 addr_err strobe", addr_err, 1);
    chk(cur_buf == 2'b11, "R7 stays disabled", cur_buf, 2'b11);
    // R7 same bounds without dual: buf1 not checked
    dual = 0;
    pulse_start();
    chk(cur_buf == 2'b00, "R7 R10 start ok resumes buffer 0", cur_buf, 0);

    // Table of frames on buffer 0
    foreach (VECS[i]) begin
      pm = VECS[i].pm; tft = VECS[i].tft; w = VECS[i].w; h = VECS[i].h; sp = VECS[i].sp;
      pal_word = {1'b0, VECS[i].code, 12'h5A5};
      r0 = req_cnt;
      run_frame(kind);
      chk(kind == int'(VECS[i].kind), $sformatf("R2 R4 vec%0d outcome", i), kind, VECS[i].kind);
      chk(req_cnt - r0 == ((VECS[i].pm != 2'd2) ? 1 : 0), $sformatf("R1 vec%0d header reads", i),
          req_cnt - r0, (VECS[i].pm != 2'd2) ? 1 : 0);
      if (VECS[i].pm != 2'd2)
        chk(last_addr == b0t, $sformatf("R1 vec%0d header addr", i), last_addr, b0t);
      if (VECS[i].kind == 2'd0) begin
        chk(bpp == VECS[i].bpp, $sformatf("R2 vec%0d bpp", i), bpp, VECS[i].bpp);
        chk(fetch_base == b0t + VECS[i].off, $sformatf("R3 vec%0d fetch base", i),
            fetch_base, b0t + VECS[i].off);
        chk(line_bytes == VECS[i].lb, $sformatf("R5 vec%0d line bytes", i), line_bytes, VECS[i].lb);
        chk(frame_buf == 1'b0, $sformatf("R5 vec%0d frame buf", i), frame_buf, 0);
        chk(first_line == VECS[i].first && line_cnt == VECS[i].cnt,
            $sformatf("R8 vec%0d window", i), {first_line, line_cnt}, {VECS[i].first, VECS[i].cnt});
        chk(pix16 == (VECS[i].tft && VECS[i].bpp == 5'd16), $sformatf("R9 vec%0d pix16", i),
            pix16, VECS[i].tft && VECS[i].bpp == 5'd16);
      end else begin
        chk(cur_buf == 2'b00, $sformatf("R2 vec%0d still enabled after skip", i), cur_buf, 0);
      end
    end

    // R4 exact fit: 0x200 + 127*127*2 = 0x8002 = size + 2
    pm = 0; sp = 0; tft = 0; w = 11'd127; h = 11'd127; pal_word = 16'h5000;
    run_frame(kind);
    chk(kind == 0, "R4 exact fit accepted", kind, 0);
    b0e = 32'h8FFF;
    run_frame(kind);
    chk(kind == 2, "R4 one byte over gives sync error", kind, 2);
    @(negedge clk);
    chk(cur_buf == 2'b11, "R4 disabled after sync error", cur_buf, 2'b11);
    r0 = req_cnt;
    run_frame(kind);
    chk(kind == -1 && req_cnt == r0, "R11 no frame after sync error", kind, -1);
    b0e = 32'h9000;

    // R6 dual ping-pong
    hi = 32'h30000; dual = 1; w = 11'd8; h = 11'd8; pal_word = 16'h3000;
    pulse_start();
    for (int f = 0; f < 3; f++) begin
      run_frame(kind);
      chk(kind == 0 && frame_buf == f[0], $sformatf("R6 frame %0d buffer", f), frame_buf, f[0]);
      chk(last_addr == (f[0] ? b1t : b0t), $sformatf("R6 frame %0d header addr", f),
          last_addr, f[0] ? b1t : b0t);
      chk(fetch_base == (f[0] ? b1t : b0t) + 32'h200, $sformatf("R6 R3 frame %0d base", f),
          fetch_base, (f[0] ? b1t : b0t) + 32'h200);
    end
    @(negedge clk);
    chk(cur_buf == 2'b01, "R6 index toggled", cur_buf, 2'b01);
    pulse_stop();
    chk(cur_buf == 2'b11, "R10 idle marker after stop", cur_buf, 2'b11);
    pulse_start();
    chk(cur_buf == 2'b00, "R10 restart at buffer 0", cur_buf, 0);

    // R11 stop in the completion cycle (no header mode)
    pm = 2;
    @(negedge clk) tick = 1;
    @(negedge clk) begin tick = 0; stop = 1; end
    @(negedge clk) stop = 0;
    kind = -1;
    for (int i = 0; i < 10; i++) begin
      if (frame_ok || skip || sync_err) kind = 0;
      @(negedge clk);
    end
    chk(kind == -1, "R11 stop beats completing frame", kind, -1);
    chk(cur_buf == 2'b11, "R11 disabled after stop", cur_buf, 2'b11);
    // R11 start and stop together
    @(negedge clk) begin start = 1; stop = 1; end
    @(negedge clk) begin start = 0; stop = 0; end
    @(negedge clk);
    chk(cur_buf == 2'b11, "R11 stop outranks start", cur_buf, 2'b11);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule